// File: doc/BRIEF.md
# AES Byte Step Unit

This block is an execution unit for the 32-bit AES instruction forms. Each operation takes an accumulator word, a source word, a 2-bit byte index and a 2-bit mode. The unit picks one byte of the source word and passes it through either the forward or the inverse substitution box. In the two middle-round modes, it then spreads the substituted byte over a full column word, using the forward or the inverse column-mixing coefficients. The unit rotates the column word to the byte index's position and XORs it into the accumulator.

Software builds one full cipher round from sixteen of these operations. Each of the four output columns starts with its round-key word in the accumulator. That column then receives four steps, one for each row. Step `i` takes row `i` from the source column `(j+i) mod 4`, so the choice of source register performs the row shifting. The substitution logic is computed as a GF(2^8) inversion plus an affine map, with no lookup table. A register between the substitution stage and the mix/rotate/XOR stage keeps the cycle time short. Results appear two cycles after issue, with a valid flag and a caller tag that travel alongside.

Top module: `aes_bytestep`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is 0 after that edge.
- R2: An operation issued with `in_valid`=1 at edge k produces `out_valid`=1 after edge k+2, with `out_tag` equal to its `in_tag`. `out_valid` is 0 when no operation was issued two edges earlier.
- R3: Mode 2'b00 (encrypt, final round) gives `in_acc` XOR (S(b) << 8·sel), where S is the forward AES substitution (for example S(0x00)=0x63 and S(0x53)=0xED).
- R4: Mode 2'b01 (encrypt, middle round) gives `in_acc` XOR rotl32({3·s, s, s, 2·s}, 8·sel), with s=S(b), bytes listed most significant first, and products in GF(2^8) modulo 0x11B.
- R5: Mode 2'b10 (decrypt, final round) gives `in_acc` XOR (Si(b) << 8·sel), where Si is the inverse substitution (Si(0x63)=0x00, Si(0xED)=0x53).
- R6: Mode 2'b11 (decrypt, middle round) gives `in_acc` XOR rotl32({0B·t, 0D·t, 09·t, 0E·t}, 8·sel), with t=Si(b).
- R7: The byte b is `in_src[8·sel+7 : 8·sel]`. No other byte of `in_src` affects the result.
- R8: A new operation can be issued on every cycle. Back-to-back operations each return their own result and tag, in issue order.
- R9: Sixteen mode-01 steps arranged as columns (accumulator preloaded with the round-key word, step i using row i of source column (j+i) mod 4, column words little-endian) reproduce one standard AES round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_tag | input | TAG_W | Caller tag returned with the result |
| in_acc | input | 32 | Accumulator word the result is XORed into |
| in_src | input | 32 | Word holding the byte to substitute |
| in_sel | input | 2 | Index of the byte of `in_src`, also the rotation amount |
| in_mode | input | 2 | bit1: inverse direction, bit0: middle round (mix) |
| out_valid | output | 1 | Result valid |
| out_tag | output | TAG_W | Tag of the returned operation |
| out_word | output | 32 | Accumulated result |

## Verification
On every cycle, the bound checker enforces the two-cycle timing of the valid flag and the tag. It also checks that a final-mode result differs from the accumulator only in the selected byte lane. For encrypt-middle results, it checks that the un-rotated difference has the {3s, s, s, 2s} shape. The checker cannot tell whether a substituted value is correct. Only the bench's directed scenarios can show that, by comparing against an independently generated substitution table, the published single-round vector, stray bytes in the unselected source lanes, and streams issued back to back.

// File: rtl/aes_bs_pkg.sv
package aes_bs_pkg;

  typedef enum logic [1:0] {
    MD_ENC_LAST = 2'b00,
    MD_ENC_MID  = 2'b01,
    MD_DEC_LAST = 2'b10,
    MD_DEC_MID  = 2'b11
  } step_mode_e;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;

  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    gf_dbl = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    gf_mul = acc;
  endfunction

  // x^254 equals the multiplicative inverse in GF(2^8); 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = x;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    gf_inv = r;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] v, input int n);
    rol8 = (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] fwd_affine(input logic [7:0] v);
    fwd_affine = v ^ rol8(v, 1) ^ rol8(v, 2) ^ rol8(v, 3) ^ rol8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_affine(input logic [7:0] v);
    inv_affine = rol8(v, 1) ^ rol8(v, 3) ^ rol8(v, 6) ^ 8'h05;
  endfunction

  // column coefficient for output lane (LSB lane = 0) fed by row 0
  function automatic logic [7:0] mix_coef(input logic inv, input int lane);
    logic [7:0] c;
    case (lane)
      0:       c = inv ? 8'h0E : 8'h02;
      1:       c = inv ? 8'h09 : 8'h01;
      2:       c = inv ? 8'h0D : 8'h01;
      default: c = inv ? 8'h0B : 8'h03;
    endcase
    mix_coef = c;
  endfunction

  function automatic logic [31:0] rotl_lanes(input logic [31:0] w, input logic [1:0] n);
    logic [31:0] r;
    case (n)
      2'd0:    r = w;
      2'd1:    r = {w[23:0], w[31:24]};
      2'd2:    r = {w[15:0], w[31:16]};
      default: r = {w[7:0],  w[31:8]};
    endcase
    rotl_lanes = r;
  endfunction

endpackage

// File: rtl/aes_bs_sbox.sv
module aes_bs_sbox
  import aes_bs_pkg::*;
(
  input  logic [7:0] din,
  input  logic       inv,
  output logic [7:0] dout
);
  logic [7:0] pre;
  logic [7:0] recip;

  // one shared field inverter serves both directions
  always_comb begin
    pre   = inv ? inv_affine(din) : din;
    recip = gf_inv(pre);
    dout  = inv ? recip : fwd_affine(recip);
  end
endmodule

// File: rtl/aes_bs_expand.sv
module aes_bs_expand
  import aes_bs_pkg::*;
#(
  parameter int LANE_CNT = LANES
) (
  input  logic [7:0]            sub_byte,
  input  logic [1:0]            mode,
  input  logic [1:0]            sel,
  output logic [8*LANE_CNT-1:0] word
);
  localparam int WW = 8 * LANE_CNT;
  logic [WW-1:0] raw;

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    logic [7:0] prod;
    always_comb begin
      prod = gf_mul(sub_byte, mix_coef(mode[1], g));
      if (mode[0])     raw[8*g +: 8] = prod;
      else if (g == 0) raw[8*g +: 8] = sub_byte;
      else             raw[8*g +: 8] = 8'h00;
    end
  end

  assign word = rotl_lanes(raw, sel);
endmodule

// File: rtl/aes_bytestep.sv
module aes_bytestep
  import aes_bs_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [31:0]      in_acc,
  input  logic [31:0]      in_src,
  input  logic [1:0]       in_sel,
  input  logic [1:0]       in_mode,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic [31:0]      out_word
);
  localparam int NB = WORD_W / BYTE_W;

  // byte pick
  logic [7:0] src_b [NB];
  for (genvar g = 0; g < NB; g++) begin : g_pick
    assign src_b[g] = in_src[8*g +: 8];
  end

  logic [7:0] sub_now;
  aes_bs_sbox sbox_i (
    .din  (src_b[in_sel]),
    .inv  (in_mode[1]),
    .dout (sub_now)
  );

  // stage 1: substitution result
  logic             s1_v;
  logic [TAG_W-1:0] s1_tag;
  logic [31:0]      s1_acc;
  logic [1:0]       s1_sel;
  logic [1:0]       s1_mode;
  logic [7:0]       s1_sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
    end
    if (in_valid) begin
      s1_tag  <= in_tag;
      s1_acc  <= in_acc;
      s1_sel  <= in_sel;
      s1_mode <= in_mode;
      s1_sub  <= sub_now;
    end
  end

  // stage 2: expand, rotate, accumulate
  logic [31:0] spread;
  aes_bs_expand #(.LANE_CNT(NB)) expand_i (
    .sub_byte (s1_sub),
    .mode     (s1_mode),
    .sel      (s1_sel),
    .word     (spread)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= s1_v;
    end
    if (s1_v) begin
      out_tag  <= s1_tag;
      out_word <= s1_acc ^ spread;
    end
  end
endmodule

// File: rtl/aes_bytestep_chk.sv
module aes_bytestep_chk
  import aes_bs_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [TAG_W-1:0] in_tag,
  input logic [31:0]      in_acc,
  input logic [1:0]       in_sel,
  input logic [1:0]       in_mode,
  input logic             out_valid,
  input logic [TAG_W-1:0] out_tag,
  input logic [31:0]      out_word
);
  logic [1:0]       armed_cnt;
  logic             rst_q = 1'b0;
  logic             v_d1, v_d2;
  logic [TAG_W-1:0] t_d1, t_d2;
  logic [31:0]      a_d1, a_d2;
  logic [1:0]       s_d1, s_d2, m_d1, m_d2;

  always_ff @(posedge clk) begin
    if (rst) armed_cnt <= 2'd0;
    else if (armed_cnt != 2'd2) armed_cnt <= armed_cnt + 2'd1;
    v_d1 <= in_valid; v_d2 <= v_d1;
    t_d1 <= in_tag;   t_d2 <= t_d1;
    a_d1 <= in_acc;   a_d2 <= a_d1;
    s_d1 <= in_sel;   s_d2 <= s_d1;
    m_d1 <= in_mode;  m_d2 <= m_d1;
  end

  wire armed = (armed_cnt == 2'd2);

  logic [31:0] diff, unrot;
  always_comb begin
    diff  = out_word ^ a_d2;
    unrot = rotl_lanes(diff, 2'd0 - s_d2);
  end

  // R1: reset clears the output valid
  always_ff @(posedge clk) begin
    if (rst_q) assert_reset_clears_R1: assert (!out_valid);
    rst_q <= rst;
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == v_d2));

  assert_tag_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid) |-> (out_tag == t_d2));

  // R3 and R5: final modes touch only the selected lane
  assert_final_single_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && v_d2 && !m_d2[0]) |-> (unrot[31:8] == 24'h0));

  assert_encmid_shape_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && v_d2 && m_d2 == MD_ENC_MID) |->
      (unrot[15:8] == unrot[23:16] && unrot[31:24] == (unrot[7:0] ^ unrot[15:8])));
endmodule

bind aes_bytestep aes_bytestep_chk #(.TAG_W(TAG_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
  .in_acc(in_acc), .in_sel(in_sel), .in_mode(in_mode),
  .out_valid(out_valid), .out_tag(out_tag), .out_word(out_word)
);

// File: tb/aes_bytestep_tb_top.sv
module aes_bytestep_tb_top;
  localparam int TAG_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [31:0]      in_acc = '0;
  logic [31:0]      in_src = '0;
  logic [1:0]       in_sel = '0;
  logic [1:0]       in_mode = '0;
  logic             out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [31:0]      out_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] sb  [256];
  logic [7:0] isb [256];

  always #4 clk = ~clk;

  aes_bytestep #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
    .in_acc(in_acc), .in_src(in_src), .in_sel(in_sel), .in_mode(in_mode),
    .out_valid(out_valid), .out_tag(out_tag), .out_word(out_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
  endfunction

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) r ^= x;
      x = xt(x);
      y = y >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] r8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // table from the generator-3 walk
  task automatic build_tables();
    logic [7:0] p = 1, q = 1, x;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ r8(q, 1) ^ r8(q, 2) ^ r8(q, 3) ^ r8(q, 4);
      sb[p] = x ^ 8'h63;
    end while (p != 1);
    sb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);
  endtask

  function automatic logic [31:0] model(input logic [31:0] acc, input logic [31:0] src,
                                        input logic [1:0] sel, input logic [1:0] mode);
    logic [7:0] b, t;
    logic [31:0] w;
    b = src[8*sel +: 8];
    t = mode[1] ? isb[b] : sb[b];
    case (mode)
      2'b01:   w = {bmul(t, 8'h03), t, t, bmul(t, 8'h02)};
      2'b11:   w = {bmul(t, 8'h0B), bmul(t, 8'h0D), bmul(t, 8'h09), bmul(t, 8'h0E)};
      default: w = {24'h0, t};
    endcase
    w = (w << (8 * sel)) | (w >> (32 - 8 * sel));
    return acc ^ w;
  endfunction

  task automatic do_op(input logic [31:0] acc, input logic [31:0] src, input logic [1:0] sel,
                       input logic [1:0] mode, input logic [TAG_W-1:0] tag,
                       output logic [31:0] res, output logic [TAG_W-1:0] rtag, output logic rv);
    @(negedge clk);
    in_valid = 1; in_acc = acc; in_src = src; in_sel = sel; in_mode = mode; in_tag = tag;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    @(posedge clk);
    @(negedge clk);
    res = out_word; rtag = out_tag; rv = out_valid;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", {31'h0, out_valid}, 32'h0);
    rst = 0;
  endtask

  task automatic t_mode(input logic [1:0] mode, input string req);
    logic [31:0] r; logic [TAG_W-1:0] tg; logic v;
    logic [31:0] srcs [4] = '{32'h00000053, 32'hC3A5_1F00, 32'h12345678, 32'hFFEE8001};
    for (int k = 0; k < 4; k++) begin
      logic [31:0] acc = 32'h0BAD_F00D * (k + 1);
      do_op(acc, srcs[k], 2'(k), mode, 4'(k + 5), r, tg, v);
      check(req, r, model(acc, srcs[k], 2'(k), mode));
      check("R2 valid", {31'h0, v}, 32'h1);
      check("R2 tag", {28'h0, tg}, 32'(k + 5));
    end
  endtask

  task automatic t_known();
    logic [31:0] r; logic [TAG_W-1:0] tg; logic v;
    do_op(32'h0, 32'h0000_0053, 2'd0, 2'b00, 4'h1, r, tg, v);
    check("R3 S(53)", r, 32'h0000_00ED);
    do_op(32'h0, 32'h0000_0000, 2'd2, 2'b00, 4'h1, r, tg, v);
    check("R3 S(00) lane2", r, 32'h0063_0000);
    do_op(32'h0, 32'h6300_0000, 2'd3, 2'b10, 4'h1, r, tg, v);
    check("R5 Si(63)", r, 32'h0000_0000);
    do_op(32'hFFFF_FFFF, 32'h0000_ED00, 2'd1, 2'b10, 4'h1, r, tg, v);
    check("R5 Si(ED)", r, 32'hFFFF_ACFF);
  endtask

  task automatic t_select();
    logic [31:0] r0, r1; logic [TAG_W-1:0] tg; logic v;
    for (int s = 0; s < 4; s++) begin
      logic [31:0] keep = 32'h0000_00A7 << (8 * s);
      do_op(32'h1357_9BDF, keep, 2'(s), 2'b11, 4'h2, r0, tg, v);
      do_op(32'h1357_9BDF, keep | (~(32'hFF << (8 * s)) & 32'h5C3E_9164), 2'(s), 2'b11, 4'h2, r1, tg, v);
      check("R7 other lanes ignored", r1, r0);
      check("R7 lane pick", r0, model(32'h1357_9BDF, keep, 2'(s), 2'b11));
    end
  endtask

  task automatic t_stream();
    logic [31:0] acc [4] = '{32'h1, 32'h22, 32'h333, 32'h4444};
    logic [31:0] src [4] = '{32'hA1B2C3D4, 32'h0F1E2D3C, 32'h99887766, 32'h10203040};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R8 stream valid", {31'h0, out_valid}, 32'h1);
        check("R8 stream tag", {28'h0, out_tag}, 32'(k + 6));
        check("R8 stream data", out_word, model(acc[k-2], src[k-2], 2'(k + 1), 2'(k)));
      end
      if (k < 4) begin
        in_valid = 1; in_acc = acc[k]; in_src = src[k];
        in_sel = 2'(k + 3); in_mode = 2'(k + 2); in_tag = 4'(k + 8);
      end else in_valid = 0;
    end
    @(negedge clk);
    check("R2 idle after stream", {31'h0, out_valid}, 32'h0);
  endtask

  task automatic t_round();
    logic [31:0] st [4] = '{32'hBEE33D19, 32'h2BE2F4A0, 32'h2A8DC69A, 32'h0848F8E9};
    logic [31:0] rk [4] = '{32'h17FEFAA0, 32'hB12C5488, 32'h3939A323, 32'h05766C2A};
    logic [31:0] ex [4] = '{32'hF27F9CA4, 32'h2B359F68, 32'h43EA5B6B, 32'h49506A02};
    logic [31:0] r; logic [TAG_W-1:0] tg; logic v;
    for (int j = 0; j < 4; j++) begin
      r = rk[j];
      for (int i = 0; i < 4; i++) do_op(r, st[(j + i) % 4], 2'(i), 2'b01, 4'(i), r, tg, v);
      check("R9 round column", r, ex[j]);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    build_tables();
    t_reset();
    t_known();
    t_mode(2'b00, "R3 enc final");
    t_mode(2'b01, "R4 enc mid");
    t_mode(2'b10, "R5 dec final");
    t_mode(2'b11, "R6 dec mid");
    t_select();
    t_stream();
    t_round();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule